// File: doc/BRIEF.md
# Configurable GPIO Port with Pin Interrupts

An eight-pin general-purpose I/O port. Each pin can be set as an input or an output. Software writes the values that the output pins drive and reads the synchronized pin levels, all through a small word-addressed register interface. Bit i of every pin-wide register belongs to pin i: pin 0 is the least significant bit and pin 7 the most significant.

A parameter selects one of two interrupt schemes. In the simple scheme, one status bit records that any pin changed level. In the channel scheme, four independent channels each watch one selected pin for a rising edge, a falling edge, a high level or a low level. Edge status is held until software clears it by writing a one. Level status follows the pin. The interrupt output is the OR of all status bits whose enable bit is set.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the direction, output data, interrupt enable and status registers all read 0, `pin_oe` and `pin_out` are 0 and `irq` is low.
- R2: A write to the direction register (address 0, 1 = output) appears on `pin_oe`, and a write to the output register (address 1) appears on `pin_out`, on the clock edge of the write. Both registers read back the value written.
- R3: The input register (address 2) returns the value that `pin_in` had two clock edges earlier. Bit i of that register is pin i.
- R4: In the simple scheme, a change on any pin sets status bit 0 on the third rising edge after the change. The bit then stays set.
- R5: Writing to the status register (address 4) clears each edge status bit whose data bit is 1. Bits written with 0 are left unchanged.
- R6: `irq` is the OR of status ANDed with the enable register (address 3). A status bit that is set but not enabled does not raise `irq`.
- R7: A channel configured with condition code 00 (rising) sets its status bit on the third edge after its pin goes from 0 to 1.
- R8: Condition code 01 (falling) sets the status bit on the third edge after its pin goes from 1 to 0.
- R9: Condition code 10 (high) makes the status bit equal the pin level three edges earlier, and a clear write has no effect on it.
- R10: Condition code 11 (low) makes the status bit equal the inverted pin level three edges earlier.
- R11: Channel k is configured at address 8+k, with the pin number in bits [2:0] and the condition code in bits [4:3]. It reacts only to the pin it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| pin_in | input | 8 | Pin levels seen at the pads |
| pin_out | output | 8 | Output data driven to the pads |
| pin_oe | output | 8 | Per-pin output enable (1 = output) |
| irq | output | 1 | Interrupt request |

## Verification
Register writes take effect on the edge that samples them, so outputs are checked on the falling edge that follows. The input register lags `pin_in` by two rising edges, and status and `irq` lag it by three: the synchronizer takes two edges and the status register takes one more. The bench changes pins on a falling edge and checks the result one cycle before it is due, where the old value must still hold, and again exactly when it is due. This catches a stage that is missing or added as well as a wrong value. Every channel, pin and condition combination is swept, and the expected levels are worked out from the condition code.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_DIR  = 4'h0;
  localparam logic [ADDR_W-1:0] A_OUT  = 4'h1;
  localparam logic [ADDR_W-1:0] A_IN   = 4'h2;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'h3;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] A_CFG0 = 4'h8;

  typedef enum logic [1:0] {
    COND_RISE = 2'b00,
    COND_FALL = 2'b01,
    COND_HIGH = 2'b10,
    COND_LOW  = 2'b11
  } cond_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [WIDTH-1:0]        wr_data,
  output logic [WIDTH-1:0]        dir_q,
  output logic [WIDTH-1:0]        out_q,
  output logic [NUM_CH-1:0]       ien_q,
  output logic [NUM_CH*SEL_W-1:0] sel_q,
  output logic [2*NUM_CH-1:0]     cond_q
);
  logic [WIDTH-1:0]        dir_d, out_d;
  logic [NUM_CH-1:0]       ien_d;
  logic [NUM_CH*SEL_W-1:0] sel_d;
  logic [2*NUM_CH-1:0]     cond_d;

  always_comb begin
    dir_d  = dir_q;
    out_d  = out_q;
    ien_d  = ien_q;
    sel_d  = sel_q;
    cond_d = cond_q;
    if (wr_en) begin
      if (addr == A_DIR) dir_d = wr_data;
      if (addr == A_OUT) out_d = wr_data;
      if (addr == A_IEN) ien_d = wr_data[NUM_CH-1:0];
      for (int k = 0; k < NUM_CH; k++) begin
        if (addr == A_CFG0 + ADDR_W'(k)) begin
          sel_d[k*SEL_W +: SEL_W] = wr_data[SEL_W-1:0];
          cond_d[2*k +: 2]        = wr_data[SEL_W +: 2];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      sel_q  <= '0;
      cond_q <= '0;
    end else if (wr_en) begin
      dir_q  <= dir_d;
      out_q  <= out_d;
      ien_q  <= ien_d;
      sel_q  <= sel_d;
      cond_q <= cond_d;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int NUM_CH   = 4,
  parameter int SEL_W    = 3,
  parameter bit ADV_MODE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WIDTH-1:0]        pin_s,
  input  logic [NUM_CH-1:0]       clr,
  input  logic [NUM_CH*SEL_W-1:0] sel,
  input  logic [2*NUM_CH-1:0]     cond,
  output logic [NUM_CH-1:0]       stat_q
);
  logic [WIDTH-1:0]  prev_q;
  logic [NUM_CH-1:0] stat_d;

  generate
    if (ADV_MODE) begin : g_chan
      for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic [SEL_W-1:0] pick;
        logic             cur, old, keep;
        cond_e            mode;
        assign pick = sel[k*SEL_W +: SEL_W];
        assign cur  = pin_s[pick];
        assign old  = prev_q[pick];
        assign mode = cond_e'(cond[2*k +: 2]);
        assign keep = stat_q[k] & ~clr[k];
        always_comb begin
          unique case (mode)
            COND_RISE: stat_d[k] = keep | (cur & ~old);
            COND_FALL: stat_d[k] = keep | (~cur & old);
            COND_HIGH: stat_d[k] = cur;
            default:   stat_d[k] = ~cur;
          endcase
        end
      end
    end else begin : g_any
      assign stat_d[0] = (stat_q[0] & ~clr[0]) | (|(pin_s ^ prev_q));
      if (NUM_CH > 1) begin : g_pad
        assign stat_d[NUM_CH-1:1] = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= pin_s;
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int NUM_CH   = 4,
  parameter bit ADV_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  rd_data,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic              irq
);
  localparam int SEL_W = $clog2(WIDTH);

  logic [1:0]              rst_pipe_q;
  logic                    rst_n_s;
  logic [WIDTH-1:0]        pin_s, dir_q, out_q;
  logic [NUM_CH-1:0]       ien_q, stat_q, clr;
  logic [NUM_CH*SEL_W-1:0] sel_q;
  logic [2*NUM_CH-1:0]     cond_q;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  gpio_sync #(.W(WIDTH)) sync_i (
    .clk(clk), .rst_n(rst_n_s), .d(pin_in), .q(pin_s)
  );

  gpio_regs #(.WIDTH(WIDTH), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) regs_i (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .dir_q(dir_q), .out_q(out_q), .ien_q(ien_q),
    .sel_q(sel_q), .cond_q(cond_q)
  );

  assign clr = (wr_en && addr == A_STAT) ? wr_data[NUM_CH-1:0] : '0;

  gpio_irq_detect #(
    .WIDTH(WIDTH), .NUM_CH(NUM_CH), .SEL_W(SEL_W), .ADV_MODE(ADV_MODE)
  ) det_i (
    .clk(clk), .rst_n(rst_n_s), .pin_s(pin_s), .clr(clr),
    .sel(sel_q), .cond(cond_q), .stat_q(stat_q)
  );

  always_comb begin
    rd_data = '0;
    unique case (addr)
      A_DIR:   rd_data = dir_q;
      A_OUT:   rd_data = out_q;
      A_IN:    rd_data = pin_s;
      A_IEN:   rd_data[NUM_CH-1:0] = ien_q;
      A_STAT:  rd_data[NUM_CH-1:0] = stat_q;
      default: begin
        for (int k = 0; k < NUM_CH; k++) begin
          if (ADV_MODE && addr == A_CFG0 + 4'(k))
            rd_data[SEL_W+1:0] = {cond_q[2*k +: 2], sel_q[k*SEL_W +: SEL_W]};
        end
      end
    endcase
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q;
  assign irq     = |(stat_q & ien_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int NUM_CH   = 4,
  parameter bit ADV_MODE = 1'b1
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              wr_en,
  input logic [3:0]        addr,
  input logic [WIDTH-1:0]  wr_data,
  input logic [WIDTH-1:0]  pin_oe,
  input logic [WIDTH-1:0]  pin_out,
  input logic              irq,
  input logic [NUM_CH-1:0] ien_q,
  input logic [NUM_CH-1:0] stat_q,
  input logic [2*NUM_CH-1:0] cond_q
);
  logic [NUM_CH-1:0] edge_m, clr_m;

  always_comb begin
    for (int k = 0; k < NUM_CH; k++)
      edge_m[k] = ADV_MODE ? ~cond_q[2*k+1] : 1'b1;
    clr_m = (wr_en && addr == A_STAT) ? wr_data[NUM_CH-1:0] : '0;
  end

  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(wr_en && addr == A_DIR) |=> $stable(pin_oe));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(wr_en && addr == A_OUT) |=> $stable(pin_out));

  // R6
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ien_q == '0) |-> !irq);

  // R5
  edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    1'b1 |=> ((($past(stat_q) & $past(edge_m) & ~$past(clr_m)) & edge_m & ~stat_q) == '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(
  .WIDTH(WIDTH), .NUM_CH(NUM_CH), .ADV_MODE(ADV_MODE)
) chk_i (
  .clk(clk), .rst_n_s(rst_n_s), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq),
  .ien_q(ien_q), .stat_q(stat_q), .cond_q(cond_q)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] rd_a, rd_s, out_a, out_s, oe_a, oe_s;
  logic       irq_a, irq_s;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_port #(.ADV_MODE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_a), .pin_in(pin_in), .pin_out(out_a), .pin_oe(oe_a), .irq(irq_a)
  );

  gpio_irq_port #(.ADV_MODE(1'b0)) dut_simple_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_s), .pin_in(pin_in), .pin_out(out_s), .pin_oe(oe_s), .irq(irq_s)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(3);
    // R1 reset state
    check("R1 oe", oe_a, 8'h00);
    check("R1 out", out_a, 8'h00);
    check("R1 irq", {7'd0, irq_a | irq_s}, 8'h00);
    addr = 4'h0; #1 check("R1 dir", rd_a, 8'h00);
    addr = 4'h3; #1 check("R1 ien", rd_a, 8'h00);
    addr = 4'h4; #1 check("R1 stat", rd_a | rd_s, 8'h00);

    // R2 direction and output sweep
    for (int v = 0; v < 256; v++) begin
      wr(4'h0, 8'(v));
      wr(4'h1, ~8'(v));
      check("R2 oe", oe_a, 8'(v));
      check("R2 out", out_a, ~8'(v));
      addr = 4'h0; #1 check("R2 dir rd", rd_a, 8'(v));
      addr = 4'h1; #1 check("R2 out rd", rd_a, ~8'(v));
    end

    // R3 input sync latency sweep
    addr = 4'h2;
    for (int v = 1; v < 257; v++) begin
      logic [7:0] prev;
      prev = 8'(v - 1);
      pin_in = 8'(v);
      step(1); check("R3 early", rd_a, prev);
      step(1); check("R3 due", rd_a, 8'(v));
    end
    pin_in = 8'h00;
    step(4);

    // R4 R5 R6 simple variant
    wr(4'h4, 8'hFF);
    wr(4'h3, 8'h00);
    pin_in = 8'h04;
    step(3);
    check("R6 masked irq", {7'd0, irq_s}, 8'h00);
    addr = 4'h4; #1 check("R6 stat set", rd_s, 8'h01);
    wr(4'h3, 8'h01);
    check("R6 enabled irq", {7'd0, irq_s}, 8'h01);
    pin_in = 8'h00; step(4);
    wr(4'h4, 8'h01);
    for (int p = 0; p < 8; p++) begin
      pin_in = 8'h01 << p;
      step(2); check("R4 early", {7'd0, irq_s}, 8'h00);
      step(1); check("R4 due", {7'd0, irq_s}, 8'h01);
      step(2); check("R4 sticky", {7'd0, irq_s}, 8'h01);
      wr(4'h4, 8'h00); check("R5 zero keeps", {7'd0, irq_s}, 8'h01);
      wr(4'h4, 8'h01); check("R5 one clears", {7'd0, irq_s}, 8'h00);
      pin_in = 8'h00;
      step(3); check("R4 fall", {7'd0, irq_s}, 8'h01);
      wr(4'h4, 8'h01);
    end

    // R7..R11 channel variant sweep
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 8; p++) begin
        for (int c = 0; c < 4; c++) begin
          logic [7:0] other;
          logic e1, e3, e4, e5;
          other = 8'h01 << (p ^ 1);
          e1 = (c == 3);
          e3 = (c == 0) || (c == 2);
          e4 = (c == 2);
          e5 = (c == 1) || (c == 3);
          wr(4'(8 + k), 8'({c[1:0], p[2:0]}));
          wr(4'h3, 8'h01 << k);
          addr = 4'(8 + k); #1 check("R11 cfg rd", rd_a, 8'({c[1:0], p[2:0]}));
          pin_in = 8'h00;
          step(4);
          wr(4'h4, 8'h0F);
          check("R10 base", {7'd0, irq_a}, {7'd0, e1});
          pin_in = other;
          step(3); check("R11 other pin", {7'd0, irq_a}, {7'd0, e1});
          pin_in = other | (8'h01 << p);
          step(2); check("R7 R9 early", {7'd0, irq_a}, {7'd0, e1});
          step(1); check("R7 R9 due", {7'd0, irq_a}, {7'd0, e3});
          wr(4'h4, 8'h0F);
          check("R9 clear", {7'd0, irq_a}, {7'd0, e4});
          pin_in = other;
          step(3); check("R8 R10 due", {7'd0, irq_a}, {7'd0, e5});
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule